// File: doc/BRIEF.md
# Keyboard and Display Register Interface

This block gives a CPU two character devices as ordinary memory locations. The keyboard side takes a one-byte character with a strobe, holds it, and sets a ready flag. It then refuses further characters until the CPU reads the captured byte. The display side takes a byte from a CPU store and hands it to the display with a start pulse. It reports busy until the display signals that it has finished. Each device has a status word and a data word on the bus. The status word carries a ready flag and an interrupt enable. Each device raises its own interrupt request when both of these are set.

The CPU side is a plain address, read strobe, write strobe and data bus. Read data is combinational for the addressed word. Side effects, such as clearing keyboard ready or starting the display, take hold on the clock edge that samples the strobe. Reset is asynchronous and active-low. Its release is synchronised inside the block, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `kbd_disp_regs`

## Requirements
- R1: The four words are decoded at fixed addresses: keyboard status 0xFE00, keyboard data 0xFE02, display status 0xFE04, display data 0xFE06. A read of any other address returns 0 and changes no state.
- R2: Bit 15 of the keyboard status word is the keyboard ready flag. It becomes 1 on the clock edge that samples `key_valid` high while ready is 0.
- R3: Bits 7:0 of the keyboard data word hold the captured character, and bits 15:8 read as 0.
- R4: While keyboard ready is 1, `key_valid` is ignored and the stored character does not change. A read of the keyboard data word while ready is 1 clears ready on that clock edge, and this also unlocks the keyboard.
- R5: A write to the display data word while display ready (display status bit 15) is 1 does three things. It puts bits 7:0 on `disp_char`. It pulses `disp_start` high for exactly the cycle after the write. It drops display ready to 0 from that same cycle.
- R6: While display ready is 0, a `disp_done` pulse sets display ready back to 1 on the next clock edge. A `disp_done` pulse while display ready is 1 has no effect.
- R7: Bit 14 of each status word is an interrupt enable that only a CPU write sets or clears. `kbd_irq` equals keyboard ready AND keyboard enable, and `disp_irq` equals display ready AND display enable.
- R8: Status bits other than 15 and 14 read as 0. CPU writes to status bit 15 are ignored. A write to the display data word while display ready is 0 is dropped: `disp_char` is unchanged and no start pulse is made.
- R9: After reset, keyboard ready is 0, display ready is 1, both enables are 0, and both interrupt requests are 0.
- R10: `bus_rdata` reflects the addressed word in the same cycle that `bus_rd` and `bus_addr` are presented, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | CPU word address |
| bus_rd | input | 1 | CPU read strobe |
| bus_wr | input | 1 | CPU write strobe |
| bus_wdata | input | 16 | CPU write data |
| bus_rdata | output | 16 | Read data for the addressed word |
| key_valid | input | 1 | Keyboard character strobe |
| key_char | input | 8 | Keyboard character |
| disp_char | output | 8 | Character handed to the display |
| disp_start | output | 1 | One-cycle pulse that starts display output |
| disp_done | input | 1 | Display has finished the current character |
| kbd_irq | output | 1 | Keyboard interrupt request |
| disp_irq | output | 1 | Display interrupt request |

## Verification
All 256 character codes are sent through the keyboard capture and read back. All 256 codes are also written to the display. Together these show that every data bit is routed correctly in both directions, and that the high byte stays zero.

Back-to-back keys, stores while the display is busy, and done pulses while idle each probe one lock rule. They separate a design that locks from one that overwrites or double-starts.

A sweep of every address from 0xFE00 to 0xFEFF is made while a key is pending. It separates a correct decoder from one that aliases odd or higher addresses, or that clears ready on a stray read.

Writes of all-ones and all-zeros to the status words show whether bit 15 can be forced and whether the enables gate the interrupt requests.

// File: rtl/kdr_pkg.sv
package kdr_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_KSTAT,
    SEL_KDATA,
    SEL_DSTAT,
    SEL_DDATA
  } reg_sel_e;
endpackage

// File: rtl/kdr_decode.sv
module kdr_decode
  import kdr_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] KSTAT_AD = 16'hFE00,
  parameter logic [15:0] KDATA_AD = 16'hFE02,
  parameter logic [15:0] DSTAT_AD = 16'hFE04,
  parameter logic [15:0] DDATA_AD = 16'hFE06
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    sel = SEL_NONE;
    if (addr == KSTAT_AD[ADDR_W-1:0]) sel = SEL_KSTAT;
    if (addr == KDATA_AD[ADDR_W-1:0]) sel = SEL_KDATA;
    if (addr == DSTAT_AD[ADDR_W-1:0]) sel = SEL_DSTAT;
    if (addr == DDATA_AD[ADDR_W-1:0]) sel = SEL_DDATA;
  end
endmodule

// File: rtl/kdr_kbd_port.sv
module kdr_kbd_port #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [CHAR_W-1:0] key_char,
  input  logic              ie_wr,
  input  logic              ie_wdata,
  input  logic              data_rd,
  output logic              ready,
  output logic              ie,
  output logic [CHAR_W-1:0] char_q
);
  logic              ready_d, ie_d, char_en;
  logic [CHAR_W-1:0] char_d;

  always_comb begin
    ready_d = ready;
    ie_d    = ie_wr ? ie_wdata : ie;
    char_en = 1'b0;
    char_d  = key_char;
    if (ready) begin
      if (data_rd) ready_d = 1'b0;
    end else if (key_valid) begin
      ready_d = 1'b1;
      char_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready  <= 1'b0;
      ie     <= 1'b0;
      char_q <= '0;
    end else begin
      ready <= ready_d;
      ie    <= ie_d;
      if (char_en) char_q <= char_d;
    end
  end
endmodule

// File: rtl/kdr_disp_port.sv
module kdr_disp_port #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_wr,
  input  logic [CHAR_W-1:0] wchar,
  input  logic              ie_wr,
  input  logic              ie_wdata,
  input  logic              done,
  output logic              ready,
  output logic              ie,
  output logic [CHAR_W-1:0] char_q,
  output logic              start
);
  logic ready_d, ie_d, start_d, char_en;

  always_comb begin
    ready_d = ready;
    ie_d    = ie_wr ? ie_wdata : ie;
    start_d = 1'b0;
    char_en = 1'b0;
    if (ready) begin
      if (char_wr) begin
        ready_d = 1'b0;
        start_d = 1'b1;
        char_en = 1'b1;
      end
    end else if (done) begin
      ready_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready  <= 1'b1;
      ie     <= 1'b0;
      start  <= 1'b0;
      char_q <= '0;
    end else begin
      ready <= ready_d;
      ie    <= ie_d;
      start <= start_d;
      if (char_en) char_q <= wchar;
    end
  end
endmodule

// File: rtl/kbd_disp_regs.sv
module kbd_disp_regs
  import kdr_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 16,
  parameter int          CHAR_W   = 8,
  parameter logic [15:0] KSTAT_AD = 16'hFE00,
  parameter logic [15:0] KDATA_AD = 16'hFE02,
  parameter logic [15:0] DSTAT_AD = 16'hFE04,
  parameter logic [15:0] DDATA_AD = 16'hFE06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              key_valid,
  input  logic [CHAR_W-1:0] key_char,
  output logic [CHAR_W-1:0] disp_char,
  output logic              disp_start,
  input  logic              disp_done,
  output logic              kbd_irq,
  output logic              disp_irq
);
  localparam int RDY_BIT = DATA_W - 1;
  localparam int IE_BIT  = DATA_W - 2;
  localparam int SYNC_N  = 2;

  // reset: asserted at once, released through a short flop chain
  logic [SYNC_N-1:0] rst_sync;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync[SYNC_N-1];

  reg_sel_e          sel;
  logic              k_ready, k_ie, d_ready, d_ie;
  logic [CHAR_W-1:0] k_char;
  logic              k_data_rd, k_ie_wr, d_ie_wr, d_char_wr;
  logic              unused_wdata;

  kdr_decode #(
    .ADDR_W(ADDR_W), .KSTAT_AD(KSTAT_AD), .KDATA_AD(KDATA_AD),
    .DSTAT_AD(DSTAT_AD), .DDATA_AD(DDATA_AD)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  assign k_data_rd    = bus_rd && (sel == SEL_KDATA);
  assign k_ie_wr      = bus_wr && (sel == SEL_KSTAT);
  assign d_ie_wr      = bus_wr && (sel == SEL_DSTAT);
  assign d_char_wr    = bus_wr && (sel == SEL_DDATA);
  assign unused_wdata = ^bus_wdata;

  kdr_kbd_port #(.CHAR_W(CHAR_W)) u_kbd (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .key_valid(key_valid),
    .key_char (key_char),
    .ie_wr    (k_ie_wr),
    .ie_wdata (bus_wdata[IE_BIT]),
    .data_rd  (k_data_rd),
    .ready    (k_ready),
    .ie       (k_ie),
    .char_q   (k_char)
  );

  kdr_disp_port #(.CHAR_W(CHAR_W)) u_disp (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .char_wr (d_char_wr),
    .wchar   (bus_wdata[CHAR_W-1:0]),
    .ie_wr   (d_ie_wr),
    .ie_wdata(bus_wdata[IE_BIT]),
    .done    (disp_done),
    .ready   (d_ready),
    .ie      (d_ie),
    .char_q  (disp_char),
    .start   (disp_start)
  );

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_KSTAT: begin
        bus_rdata[RDY_BIT] = k_ready;
        bus_rdata[IE_BIT]  = k_ie;
      end
      SEL_KDATA: bus_rdata[CHAR_W-1:0] = k_char;
      SEL_DSTAT: begin
        bus_rdata[RDY_BIT] = d_ready;
        bus_rdata[IE_BIT]  = d_ie;
      end
      SEL_DDATA: bus_rdata[CHAR_W-1:0] = disp_char;
      default:   bus_rdata = '0;
    endcase
  end

  assign kbd_irq  = k_ready & k_ie;
  assign disp_irq = d_ready & d_ie;
endmodule

// File: rtl/kdr_checker.sv
module kdr_checker #(
  parameter int          ADDR_W   = 16,
  parameter int          CHAR_W   = 8,
  parameter logic [15:0] KSTAT_AD = 16'hFE00,
  parameter logic [15:0] KDATA_AD = 16'hFE02,
  parameter logic [15:0] DDATA_AD = 16'hFE06
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              key_valid,
  input logic              k_ready,
  input logic [CHAR_W-1:0] k_char,
  input logic              d_ready,
  input logic              disp_start,
  input logic              disp_done,
  input logic [CHAR_W-1:0] disp_char
);
  logic rd_kdata, wr_ddata, wr_kstat;
  assign rd_kdata = bus_rd && (bus_addr == KDATA_AD[ADDR_W-1:0]);
  assign wr_ddata = bus_wr && (bus_addr == DDATA_AD[ADDR_W-1:0]);
  assign wr_kstat = bus_wr && (bus_addr == KSTAT_AD[ADDR_W-1:0]);

  assert_kbd_lock_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (k_ready && !rd_kdata) |=> (k_ready && $stable(k_char)));

  assert_kbd_clear_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (k_ready && rd_kdata) |=> !k_ready);

  assert_kbd_capture_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!k_ready && key_valid) |=> k_ready);

  assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    disp_start |-> !d_ready);

  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!d_ready && wr_ddata) |=> (!disp_start && $stable(disp_char)));

  assert_done_return_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!d_ready && disp_done) |=> d_ready);

  assert_rdy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_kstat && !key_valid && !rd_kdata) |=> (k_ready == $past(k_ready)));
endmodule

bind kbd_disp_regs kdr_checker #(
  .ADDR_W(ADDR_W), .CHAR_W(CHAR_W),
  .KSTAT_AD(KSTAT_AD), .KDATA_AD(KDATA_AD), .DDATA_AD(DDATA_AD)
) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .key_valid (key_valid),
  .k_ready   (k_ready),
  .k_char    (k_char),
  .d_ready   (d_ready),
  .disp_start(disp_start),
  .disp_done (disp_done),
  .disp_char (disp_char)
);

// File: tb/test_kbd_disp_regs.sv
module test_kbd_disp_regs;
  localparam logic [15:0] A_KS = 16'hFE00;
  localparam logic [15:0] A_KD = 16'hFE02;
  localparam logic [15:0] A_DS = 16'hFE04;
  localparam logic [15:0] A_DD = 16'hFE06;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        key_valid;
  logic [7:0]  key_char, disp_char;
  logic        disp_start, disp_done, kbd_irq, disp_irq;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  kbd_disp_regs i_kbd_disp_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .key_valid(key_valid), .key_char(key_char), .disp_char(disp_char),
    .disp_start(disp_start), .disp_done(disp_done),
    .kbd_irq(kbd_irq), .disp_irq(disp_irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // read data sampled before the edge (combinational), strobe held over one edge
  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic key(input logic [7:0] c);
    @(negedge clk);
    key_char = c; key_valid = 1'b1;
    @(posedge clk); #1 key_valid = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    disp_done = 1'b1;
    @(posedge clk); #1 disp_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    key_valid = 0; key_char = '0; disp_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state, R10 combinational read
    rd(A_KS, d); check("R9 kstat", d, 16'h0000);
    rd(A_DS, d); check("R9 dstat", d, 16'h8000);
    check("R9 kbd_irq", {15'b0, kbd_irq}, 16'h0);
    check("R9 disp_irq", {15'b0, disp_irq}, 16'h0);

    // R2 R3 R4 R10: every character through the keyboard
    for (int c = 0; c < 256; c++) begin
      key(c[7:0]);
      rd(A_KS, d); check("R2 ready set", d, 16'h8000);
      rd(A_KD, d); check("R3 char", d, {8'h00, c[7:0]});
      rd(A_KS, d); check("R4 ready cleared", d, 16'h0000);
    end

    // R4 lock: second key ignored while pending
    key(8'h41); key(8'h42);
    rd(A_KD, d); check("R4 locked char", d, 16'h0041);
    key(8'h43);
    rd(A_KD, d); check("R4 unlocked char", d, 16'h0043);

    // R1: address sweep with a key pending, no side effect
    key(8'h5A);
    for (int a = 16'hFE00; a <= 16'hFEFF; a++) begin
      if (a != A_KS && a != A_KD && a != A_DS && a != A_DD) begin
        rd(a[15:0], d); check("R1 undecoded", d, 16'h0000);
      end
    end
    rd(A_KS, d); check("R1 ready kept", d, 16'h8000);

    // R8: write to bit 15 ignored, other bits zero
    wr(A_KS, 16'h0000);
    rd(A_KS, d); check("R8 ready not cleared", d, 16'h8000);
    rd(A_KD, d); check("R3 pending char", d, 16'h005A);
    wr(A_KS, 16'hFFFF);
    rd(A_KS, d); check("R8 ready not set", d, 16'h4000);

    // R7 keyboard interrupt
    check("R7 kirq idle", {15'b0, kbd_irq}, 16'h0);
    key(8'h31);
    check("R7 kirq raised", {15'b0, kbd_irq}, 16'h1);
    wr(A_KS, 16'h0000);
    check("R7 kirq masked", {15'b0, kbd_irq}, 16'h0);
    wr(A_KS, 16'h4000);
    check("R7 kirq unmasked", {15'b0, kbd_irq}, 16'h1);
    rd(A_KD, d);
    check("R7 kirq cleared", {15'b0, kbd_irq}, 16'h0);

    // R5 R6: every character through the display
    for (int c = 0; c < 256; c++) begin
      wr(A_DD, {8'hA5, c[7:0]});
      check("R5 start pulse", {15'b0, disp_start}, 16'h1);
      check("R5 disp_char", {8'h00, disp_char}, {8'h00, c[7:0]});
      rd(A_DS, d); check("R5 busy", d, 16'h0000);
      check("R5 start single", {15'b0, disp_start}, 16'h0);
      rd(A_DD, d); check("R3 ddata high zero", d, {8'h00, c[7:0]});
      done_pulse();
      rd(A_DS, d); check("R6 ready back", d, 16'h8000);
    end

    // R8 dropped write while busy, R6 done while idle
    wr(A_DD, 16'h0011);
    wr(A_DD, 16'h0022);
    check("R8 no restart", {15'b0, disp_start}, 16'h0);
    check("R8 char kept", {8'h00, disp_char}, 16'h0011);
    done_pulse();
    done_pulse();
    rd(A_DS, d); check("R6 done idle", d, 16'h8000);

    // R7 display interrupt
    wr(A_DS, 16'hFFFF);
    rd(A_DS, d); check("R8 dstat bits", d, 16'hC000);
    check("R7 dirq ready", {15'b0, disp_irq}, 16'h1);
    wr(A_DD, 16'h0033);
    check("R7 dirq busy", {15'b0, disp_irq}, 16'h0);
    done_pulse();
    check("R7 dirq back", {15'b0, disp_irq}, 16'h1);
    wr(A_DS, 16'h0000);
    check("R7 dirq masked", {15'b0, disp_irq}, 16'h0);

    finish_run();
  end
endmodule